// File: doc/BRIEF.md
# Transactional Snoop Responder

This block decides how one cache line answers a snooped bus cycle in a write-once style coherence scheme that has transactional bus cycles added. The same logic serves the ordinary data cache and the small transactional cache. A select input says which of the two owns the line. For each snoop, the block takes the bus cycle kind, whether the address hit, the line's coherence state and, for the transactional cache, the line's transaction tag. It returns the state the line must take, whether the line supplies data on the bus, and whether the snoop is refused with a BUSY answer.

The rules favour transactions already in progress. A transactional read or read-for-ownership that reaches a line the transactional cache holds DIRTY or RESERVED is refused, and the line is left as it is. The transactional cache answers ordinary reads only for lines tagged NORMAL; lines that carry tentative data stay invisible to ordinary traffic. If a snoop takes away or downgrades a line tagged as part of the running transaction (XCOMMIT or XABORT), a conflict output tells the core to clear its transaction status. Writeback cycles and misses are left to main memory.

With the default parameter, the answer is registered and appears one clock after the snoop is presented.

Top module: `snoop_responder`

## Requirements
- R1: While `rst_n` is low, and after any clock edge where it was low, `rsp_valid`, `rsp_state`, `rsp_update`, `rsp_supply`, `rsp_busy` and `rsp_conflict` are all 0.
- R2: A snoop presented with `snp_valid` high at a rising edge produces its answer, with `rsp_valid` high, after that edge. A cycle without `snp_valid` yields all outputs 0 after the next edge.
- R3: Encodings are fixed as follows. Bus kind: READ=0, RFO=1, WRITE=2, T_READ=3, T_RFO=4; other values are unused. Line state: INVALID=0, VALID=1, DIRTY=2, RESERVED=3. Tag: EMPTY=0, NORMAL=1, XCOMMIT=2, XABORT=3. `snp_txc`=0 selects the regular cache. In the regular cache, READ or T_READ to a hit line that is not INVALID gives `rsp_state`=VALID with `rsp_supply`=1 and never `rsp_busy`.
- R4: In the regular cache, RFO or T_RFO to a hit line that is not INVALID gives `rsp_state`=INVALID with `rsp_supply`=1.
- R5: A snoop has no effect in any of these cases: a miss, an INVALID line, a WRITE cycle, an unused kind code, or a transactional-cache line tagged EMPTY. In each case `rsp_state` equals the current state, and supply, busy, update and conflict are 0.
- R6: In the transactional cache, READ and RFO follow the regular-cache transitions for a NORMAL-tagged line. For XCOMMIT and XABORT lines they have no effect, as in R5.
- R7: In the transactional cache, T_READ to a VALID line of any non-EMPTY tag keeps it VALID, supplies data and does not raise `rsp_update`.
- R8: In the transactional cache, T_READ or T_RFO to a DIRTY or RESERVED line of any non-EMPTY tag raises `rsp_busy`, keeps the state, and does not supply or update.
- R9: In the transactional cache, T_RFO to a VALID line of any non-EMPTY tag moves it to INVALID and supplies data.
- R10: `rsp_conflict` is 1 exactly when a transactional-cache line tagged XCOMMIT or XABORT changes state.
- R11: `rsp_busy` and `rsp_supply` are never 1 together.
- R12: While `rsp_valid` is 1, `rsp_update` is 1 exactly when `rsp_state` differs from the line state that was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_valid | input | 1 | A snooped bus cycle is present |
| snp_kind | input | 3 | Bus cycle kind code |
| snp_hit | input | 1 | Snoop address matches this line |
| snp_txc | input | 1 | 1: line lives in the transactional cache |
| line_st | input | 2 | Current coherence state of the line |
| line_tag | input | 2 | Transaction tag of the line (transactional cache only) |
| rsp_valid | output | 1 | Answer present |
| rsp_state | output | 2 | State the line must take |
| rsp_update | output | 1 | State must be written back to the line |
| rsp_supply | output | 1 | Line drives its data onto the bus |
| rsp_busy | output | 1 | Snoop refused with BUSY |
| rsp_conflict | output | 1 | Running transaction lost a line; clear transaction status |

## Verification
The bench aims at the places where the two caches' rules differ for the same input. A design that reused the regular-cache table would service a T_READ to a transactional DIRTY line instead of refusing it, or would let an ordinary READ see tentative XABORT data. The bench also covers an EMPTY-tagged line that is marked VALID, which a design testing only the state would wrongly answer. It covers a T_RFO that invalidates an XCOMMIT line and checks that the conflict is raised. It covers a WRITE cycle and a miss on a DIRTY line; a sloppy decoder would supply data or downgrade the line for these.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int KIND_W  = 3;
  localparam int STATE_W = 2;
  localparam int TAG_W   = 2;

  typedef enum logic [KIND_W-1:0] {
    BK_READ  = 3'd0,
    BK_RFO   = 3'd1,
    BK_WRITE = 3'd2,
    BK_TREAD = 3'd3,
    BK_TRFO  = 3'd4
  } bus_kind_e;

  typedef enum logic [STATE_W-1:0] {
    LS_INV   = 2'd0,
    LS_VAL   = 2'd1,
    LS_DIRTY = 2'd2,
    LS_RSV   = 2'd3
  } line_st_e;

  typedef enum logic [TAG_W-1:0] {
    TG_EMPTY   = 2'd0,
    TG_NORMAL  = 2'd1,
    TG_XCOMMIT = 2'd2,
    TG_XABORT  = 2'd3
  } tx_tag_e;

  typedef struct packed {
    logic [STATE_W-1:0] nxt;
    logic               supply;
    logic               busy;
  } snoop_act_t;

  function automatic snoop_act_t act_idle(input logic [STATE_W-1:0] cur);
    snoop_act_t a;
    a.nxt    = cur;
    a.supply = 1'b0;
    a.busy   = 1'b0;
    return a;
  endfunction

  function automatic snoop_act_t act_move(input logic [STATE_W-1:0] to);
    snoop_act_t a;
    a.nxt    = to;
    a.supply = 1'b1;
    a.busy   = 1'b0;
    return a;
  endfunction

  function automatic logic owned_excl(input logic [STATE_W-1:0] st);
    return (st == LS_DIRTY) || (st == LS_RSV);
  endfunction

  function automatic logic tentative_tag(input logic [TAG_W-1:0] tg);
    return (tg == TG_XCOMMIT) || (tg == TG_XABORT);
  endfunction

endpackage

// File: rtl/snp_reg_rules.sv
module snp_reg_rules
  import snoop_pkg::*;
(
  input  logic [KIND_W-1:0]  kind,
  input  logic [STATE_W-1:0] cur,
  input  logic               live,
  output snoop_act_t         act
);

  function automatic snoop_act_t decide(input logic [KIND_W-1:0] k,
                                        input logic [STATE_W-1:0] s,
                                        input logic lv);
    snoop_act_t a;
    a = act_idle(s);
    if (lv) begin
      case (k)
        BK_READ, BK_TREAD: a = act_move(LS_VAL);
        BK_RFO,  BK_TRFO:  a = act_move(LS_INV);
        default:           a = act_idle(s);
      endcase
    end
    return a;
  endfunction

  always_comb act = decide(kind, cur, live);

endmodule

// File: rtl/snp_tx_rules.sv
module snp_tx_rules
  import snoop_pkg::*;
(
  input  logic [KIND_W-1:0]  kind,
  input  logic [STATE_W-1:0] cur,
  input  logic [TAG_W-1:0]   tag,
  input  logic               live,
  output snoop_act_t         act
);

  function automatic snoop_act_t decide(input logic [KIND_W-1:0] k,
                                        input logic [STATE_W-1:0] s,
                                        input logic [TAG_W-1:0] t,
                                        input logic lv);
    snoop_act_t a;
    a = act_idle(s);
    if (lv && (t != TG_EMPTY)) begin
      case (k)
        BK_READ:  if (t == TG_NORMAL) a = act_move(LS_VAL);
        BK_RFO:   if (t == TG_NORMAL) a = act_move(LS_INV);
        BK_TREAD, BK_TRFO: begin
          if (owned_excl(s)) begin
            a.nxt    = s;
            a.supply = 1'b0;
            a.busy   = 1'b1;
          end else if (k == BK_TREAD) begin
            a = act_move(LS_VAL);
          end else begin
            a = act_move(LS_INV);
          end
        end
        default: a = act_idle(s);
      endcase
    end
    return a;
  endfunction

  always_comb act = decide(kind, cur, tag, live);

endmodule

// File: rtl/snp_out_stage.sv
module snp_out_stage
  import snoop_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               d_valid,
  input  logic [STATE_W-1:0] d_state,
  input  logic               d_update,
  input  logic               d_supply,
  input  logic               d_busy,
  input  logic               d_conflict,
  output logic               q_valid,
  output logic [STATE_W-1:0] q_state,
  output logic               q_update,
  output logic               q_supply,
  output logic               q_busy,
  output logic               q_conflict
);

  localparam int BUS_W = STATE_W + 5;

  logic [BUS_W-1:0] d_bus, q_bus;

  always_comb begin
    d_bus = {BUS_W{1'b0}};
    if (d_valid)
      d_bus = {1'b1, d_state, d_update, d_supply, d_busy, d_conflict};
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_bus <= {BUS_W{1'b0}};
        else        q_bus <= d_bus;
      end
    end else begin : g_comb
      always_comb q_bus = rst_n ? d_bus : {BUS_W{1'b0}};
    end
  endgenerate

  assign {q_valid, q_state, q_update, q_supply, q_busy, q_conflict} = q_bus;

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snoop_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_valid,
  input  logic [KIND_W-1:0]  snp_kind,
  input  logic               snp_hit,
  input  logic               snp_txc,
  input  logic [STATE_W-1:0] line_st,
  input  logic [TAG_W-1:0]   line_tag,
  output logic               rsp_valid,
  output logic [STATE_W-1:0] rsp_state,
  output logic               rsp_update,
  output logic               rsp_supply,
  output logic               rsp_busy,
  output logic               rsp_conflict
);

  logic       line_live;
  snoop_act_t reg_act, tx_act, sel_act;
  logic       evt_change, evt_conflict;

  assign line_live = snp_valid && snp_hit && (line_st != LS_INV);

  snp_reg_rules u_reg_rules (
    .kind (snp_kind),
    .cur  (line_st),
    .live (line_live),
    .act  (reg_act)
  );

  snp_tx_rules u_tx_rules (
    .kind (snp_kind),
    .cur  (line_st),
    .tag  (line_tag),
    .live (line_live),
    .act  (tx_act)
  );

  assign sel_act      = snp_txc ? tx_act : reg_act;
  assign evt_change   = line_live && (sel_act.nxt != line_st);
  assign evt_conflict = evt_change && snp_txc && tentative_tag(line_tag);

  snp_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_valid    (snp_valid),
    .d_state    (sel_act.nxt),
    .d_update   (evt_change),
    .d_supply   (sel_act.supply),
    .d_busy     (sel_act.busy),
    .d_conflict (evt_conflict),
    .q_valid    (rsp_valid),
    .q_state    (rsp_state),
    .q_update   (rsp_update),
    .q_supply   (rsp_supply),
    .q_busy     (rsp_busy),
    .q_conflict (rsp_conflict)
  );

endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic       snp_txc,
  input logic [1:0] line_st,
  input logic [1:0] line_tag,
  input logic       rsp_valid,
  input logic [1:0] rsp_state,
  input logic       rsp_update,
  input logic       rsp_supply,
  input logic       rsp_busy,
  input logic       rsp_conflict
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !rsp_valid && !rsp_supply && !rsp_busy && !rsp_conflict);

  assert_never_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_busy && rsp_supply));

  assert_busy_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_busy |-> !rsp_update);

  generate
    if (OUT_REG) begin : g_timed
      assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> rsp_valid);

      assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !rsp_valid && !rsp_update && !rsp_busy);

      assert_update_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> (rsp_update == (rsp_state != $past(line_st))));

      assert_conflict_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> (rsp_conflict ==
          (rsp_update && $past(snp_txc) && ($past(line_tag) >= 2'd2))));

      assert_regular_nobusy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_txc) |=> !rsp_busy);
    end
  endgenerate

endmodule

bind snoop_responder snoop_responder_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snp_valid    (snp_valid),
  .snp_txc      (snp_txc),
  .line_st      (line_st),
  .line_tag     (line_tag),
  .rsp_valid    (rsp_valid),
  .rsp_state    (rsp_state),
  .rsp_update   (rsp_update),
  .rsp_supply   (rsp_supply),
  .rsp_busy     (rsp_busy),
  .rsp_conflict (rsp_conflict)
);

// File: tb/snoop_responder_bench.sv
module snoop_responder_bench;

  localparam time CLK_PERIOD = 10ns;

  localparam logic [2:0] K_READ = 3'd0, K_RFO = 3'd1, K_WRITE = 3'd2,
                         K_TREAD = 3'd3, K_TRFO = 3'd4, K_BAD = 3'd6;
  localparam logic [1:0] S_I = 2'd0, S_V = 2'd1, S_D = 2'd2, S_R = 2'd3;
  localparam logic [1:0] T_E = 2'd0, T_N = 2'd1, T_XC = 2'd2, T_XA = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       snp_valid = 1'b0;
  logic [2:0] snp_kind = 3'd0;
  logic       snp_hit = 1'b0;
  logic       snp_txc = 1'b0;
  logic [1:0] line_st = 2'd0;
  logic [1:0] line_tag = 2'd0;
  logic       rsp_valid, rsp_update, rsp_supply, rsp_busy, rsp_conflict;
  logic [1:0] rsp_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_responder u_snoop_responder (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_kind(snp_kind),
    .snp_hit(snp_hit), .snp_txc(snp_txc), .line_st(line_st), .line_tag(line_tag),
    .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_update(rsp_update),
    .rsp_supply(rsp_supply), .rsp_busy(rsp_busy), .rsp_conflict(rsp_conflict)
  );

  task automatic expect_out(input string req, input logic v, input logic [1:0] st,
                            input logic up, input logic sup, input logic bz,
                            input logic cf);
    logic [6:0] act, exp;
    act = {rsp_valid, rsp_state, rsp_update, rsp_supply, rsp_busy, rsp_conflict};
    exp = {v, st, up, sup, bz, cf};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual v/st/up/sup/busy/cf=%b expected %b", req, act, exp);
    end
  endtask

  // Present one snoop, then check the answer one edge later.
  task automatic snoop(input logic txc, input logic [2:0] k, input logic hit,
                       input logic [1:0] st, input logic [1:0] tg);
    @(negedge clk);
    snp_valid = 1'b1; snp_txc = txc; snp_kind = k; snp_hit = hit;
    line_st = st; line_tag = tg;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic expect_change(input string req, input logic [1:0] cur,
                               input logic [1:0] nxt, input logic sup,
                               input logic bz, input logic cf);
    expect_out(req, 1'b1, nxt, nxt != cur, sup, bz, cf);
  endtask

  task automatic t_reset_R1;
    #1;
    expect_out("R1", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    expect_out("R1", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_idle_R2;
    @(posedge clk); #1;
    expect_out("R2 idle", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_regular_R3_R4;
    for (int s = 1; s < 4; s++) begin
      snoop(1'b0, K_READ, 1'b1, 2'(s), T_E);
      expect_change("R3 READ", 2'(s), S_V, 1'b1, 1'b0, 1'b0);
      snoop(1'b0, K_TREAD, 1'b1, 2'(s), T_E);
      expect_change("R3 T_READ", 2'(s), S_V, 1'b1, 1'b0, 1'b0);
      snoop(1'b0, K_RFO, 1'b1, 2'(s), T_E);
      expect_change("R4 RFO", 2'(s), S_I, 1'b1, 1'b0, 1'b0);
      snoop(1'b0, K_TRFO, 1'b1, 2'(s), T_E);
      expect_change("R4 T_RFO", 2'(s), S_I, 1'b1, 1'b0, 1'b0);
    end
    // Response lasts only one cycle after the snoop is removed.
    @(posedge clk); #1;
    expect_out("R2 drop", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_effect_R5;
    snoop(1'b0, K_READ, 1'b0, S_D, T_E);
    expect_change("R5 miss", S_D, S_D, 1'b0, 1'b0, 1'b0);
    snoop(1'b0, K_RFO, 1'b1, S_I, T_E);
    expect_change("R5 invalid", S_I, S_I, 1'b0, 1'b0, 1'b0);
    snoop(1'b0, K_WRITE, 1'b1, S_D, T_E);
    expect_change("R5 write", S_D, S_D, 1'b0, 1'b0, 1'b0);
    snoop(1'b1, K_WRITE, 1'b1, S_V, T_XC);
    expect_change("R5 tx write", S_V, S_V, 1'b0, 1'b0, 1'b0);
    snoop(1'b0, K_BAD, 1'b1, S_V, T_E);
    expect_change("R5 bad kind", S_V, S_V, 1'b0, 1'b0, 1'b0);
    snoop(1'b1, K_TREAD, 1'b1, S_V, T_E);
    expect_change("R5 empty tag", S_V, S_V, 1'b0, 1'b0, 1'b0);
    snoop(1'b1, K_TRFO, 1'b1, S_D, T_E);
    expect_change("R5 empty tag dirty", S_D, S_D, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_tx_regular_R6;
    snoop(1'b1, K_READ, 1'b1, S_D, T_N);
    expect_change("R6 READ normal", S_D, S_V, 1'b1, 1'b0, 1'b0);
    snoop(1'b1, K_RFO, 1'b1, S_R, T_N);
    expect_change("R6 RFO normal", S_R, S_I, 1'b1, 1'b0, 1'b0);
    snoop(1'b1, K_READ, 1'b1, S_D, T_XA);
    expect_change("R6 READ xabort", S_D, S_D, 1'b0, 1'b0, 1'b0);
    snoop(1'b1, K_RFO, 1'b1, S_V, T_XC);
    expect_change("R6 RFO xcommit", S_V, S_V, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_tx_cycles_R7_R8_R9_R10;
    for (int t = 1; t < 4; t++) begin
      logic tent;
      tent = (t >= 2);
      snoop(1'b1, K_TREAD, 1'b1, S_V, 2'(t));
      expect_change("R7 T_READ valid", S_V, S_V, 1'b1, 1'b0, 1'b0);
      snoop(1'b1, K_TRFO, 1'b1, S_V, 2'(t));
      expect_change("R9 R10 T_RFO valid", S_V, S_I, 1'b1, 1'b0, tent);
      snoop(1'b1, K_TREAD, 1'b1, S_D, 2'(t));
      expect_change("R8 R11 T_READ dirty", S_D, S_D, 1'b0, 1'b1, 1'b0);
      snoop(1'b1, K_TRFO, 1'b1, S_R, 2'(t));
      expect_change("R8 R11 T_RFO reserved", S_R, S_R, 1'b0, 1'b1, 1'b0);
    end
    // Normal-tagged downgrade must not raise conflict.
    snoop(1'b1, K_READ, 1'b1, S_R, T_N);
    expect_change("R10 normal downgrade", S_R, S_V, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back_R2_R12;
    @(negedge clk);
    snp_valid = 1'b1; snp_txc = 1'b0; snp_kind = K_RFO; snp_hit = 1'b1;
    line_st = S_D; line_tag = T_E;
    @(posedge clk); #1;
    expect_change("R2 R12 first", S_D, S_I, 1'b1, 1'b0, 1'b0);
    snp_txc = 1'b1; snp_kind = K_TREAD; line_st = S_D; line_tag = T_XA;
    @(posedge clk); #1;
    expect_change("R2 R12 second", S_D, S_D, 1'b0, 1'b1, 1'b0);
    snp_valid = 1'b0;
    @(posedge clk); #1;
    expect_out("R2 after", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_again_R1;
    snoop(1'b0, K_READ, 1'b1, S_D, T_E);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R1 async", 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset_R1();
    t_idle_R2();
    t_regular_R3_R4();
    t_no_effect_R5();
    t_tx_regular_R6();
    t_tx_cycles_R7_R8_R9_R10();
    t_back_to_back_R2_R12();
    t_reset_again_R1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule